// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a word-addressed interval timer built around a down counter. Software programs a load value, a compare value and a control word through a simple write port, and reads back any of five registers through a separate read port. The counter steps down by one on each tick of the selected tick source. When it reaches zero it either reloads from the load register or wraps to all ones, depending on the mode. A compare flag is raised on the tick where the count equals the compare value. That flag drives a level interrupt when the interrupt enable is set.

Counting can be suppressed by three low-power and debug mode inputs unless the control word allows running in that mode. The control word also selects two ways of preloading the counter: on the enable edge, or on every write to the load register. It also holds a self-clearing soft reset bit. Clock generation is outside the block, so each tick source arrives as a single-cycle enable pulse in the block's own clock domain.

Top module: `ivt_timer`

## Requirements
- R1: After reset, the control word and status read 0, the load register reads 0, the count reads 0xFFFFFFFF and `irq` is low.
- R2: The count decreases by one on each clock in which the enable bit (control bit 0) is set and the tick source chosen by control bits 25:24 pulses. Code 1 selects `tick_src[0]`, code 2 selects `tick_src[1]` and code 3 selects `tick_src[2]`. Code 0 freezes the count, and pulses on unselected sources have no effect on it.
- R3: On a tick where the count is zero, the count becomes the load register value if the reload bit (control bit 3) is set, and 0xFFFFFFFF otherwise.
- R4: A control write that sets bit 0 while it was clear, with bit 1 (load on start) set in the same write, copies the load register into the count.
- R5: While control bit 17 (write-through) is set, a write to the load register also places the written value in the count at once, even with counting disabled.
- R6: Status bit 0 is set on a tick where the count equals the compare register. `irq` equals that flag gated by control bit 2.
- R7: Writing status with bit 0 set clears the flag, and writing it with bit 0 clear leaves it unchanged. If a flag-setting tick and a clearing write fall in the same cycle, the flag stays set.
- R8: A control write with bit 16 set reads back with bit 16 set for one cycle. In the next cycle bit 16 reads 0, the count is 0xFFFFFFFF and the flag is clear. The other control bits keep the written values.
- R9: While `in_stop`, `in_wait` or `in_debug` is high, ticks are ignored unless the matching run bit is set: bit 21 for stop, bit 19 for wait and bit 18 for debug.
- R10: With the enable bit clear, ticks leave both the count and the status flag unchanged.
- R11: The read offsets are 0x00 for control, 0x04 for status, 0x08 for load, 0x0C for compare and 0x10 for the count. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Byte offset of the write |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Byte offset of the read |
| rd_data | output | DW | Read data, combinational from `rd_addr` |
| tick_src | input | NSRC | Single-cycle tick pulses, one per source |
| in_stop | input | 1 | Stop mode is active |
| in_wait | input | 1 | Wait mode is active |
| in_debug | input | 1 | Debug halt is active |
| irq | output | 1 | Level interrupt |

## Verification
Every register, the count and the flag change on the rising edge that samples the write or tick, so each result can be read on the very next falling edge. `rd_data` is combinational, so reading it adds no delay. The bench drives each write or tick for exactly one clock from a falling edge and samples half a cycle after the capturing edge, so it never looks at an edge. The soft-reset bit is read at two points: on the falling edge right after the write it must show 1, and one clock later it must show 0 with the count and flag restored.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Register word index (byte offset >> 2)
    typedef enum logic [2:0] {
        IDX_CTL  = 3'd0,
        IDX_STS  = 3'd1,
        IDX_LOAD = 3'd2,
        IDX_CMP  = 3'd3,
        IDX_CNT  = 3'd4
    } ivt_idx_e;

    // Control word bit positions (software-visible layout)
    localparam int B_RUN    = 0;
    localparam int B_LDSTRT = 1;
    localparam int B_IRQEN  = 2;
    localparam int B_RELOAD = 3;
    localparam int B_SRST   = 16;
    localparam int B_THRU   = 17;
    localparam int B_DBGRUN = 18;
    localparam int B_WAITRN = 19;
    localparam int B_STOPRN = 21;
    localparam int B_SEL_LO = 24;

    typedef struct packed {
        logic [1:0] tick_sel;
        logic       stop_run;
        logic       wait_run;
        logic       dbg_run;
        logic       load_thru;
        logic       reload_sel;
        logic       irq_en;
        logic       load_on_start;
        logic       run_en;
    } ivt_ctl_t;

    function automatic ivt_ctl_t ctl_from_word(input logic [31:0] w);
        ivt_ctl_t c;
        c.tick_sel      = w[B_SEL_LO+1:B_SEL_LO];
        c.stop_run      = w[B_STOPRN];
        c.wait_run      = w[B_WAITRN];
        c.dbg_run       = w[B_DBGRUN];
        c.load_thru     = w[B_THRU];
        c.reload_sel    = w[B_RELOAD];
        c.irq_en        = w[B_IRQEN];
        c.load_on_start = w[B_LDSTRT];
        c.run_en        = w[B_RUN];
        return c;
    endfunction

    function automatic logic [31:0] ctl_to_word(input ivt_ctl_t c, input logic busy);
        logic [31:0] w;
        w                     = '0;
        w[B_SEL_LO+1:B_SEL_LO] = c.tick_sel;
        w[B_STOPRN]           = c.stop_run;
        w[B_WAITRN]           = c.wait_run;
        w[B_DBGRUN]           = c.dbg_run;
        w[B_THRU]             = c.load_thru;
        w[B_SRST]             = busy;
        w[B_RELOAD]           = c.reload_sel;
        w[B_IRQEN]            = c.irq_en;
        w[B_LDSTRT]           = c.load_on_start;
        w[B_RUN]              = c.run_en;
        return w;
    endfunction

endpackage

// File: rtl/ivt_regfile.sv
module ivt_regfile
    import ivt_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output ivt_ctl_t      ctl,
    output logic [DW-1:0] load_val,
    output logic [DW-1:0] cmp_val,
    output logic          srst_busy,
    output logic          start_load,
    output logic          thru_load,
    output logic          clr_req
);
    localparam int IW = AW - 2;

    logic [2:0] idx;
    assign idx = 3'(wr_addr[AW-1:2]);

    logic unused_lsb;
    assign unused_lsb = ^wr_addr[1:0];

    logic wr_ctl;
    assign wr_ctl     = wr_en && (idx == IDX_CTL) && (IW > 0);
    assign start_load = wr_ctl && wr_data[B_RUN] && wr_data[B_LDSTRT] && !ctl.run_en;
    assign thru_load  = wr_en && (idx == IDX_LOAD) && ctl.load_thru;
    assign clr_req    = wr_en && (idx == IDX_STS) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            load_val  <= '0;
            cmp_val   <= '0;
            srst_busy <= 1'b0;
        end else begin
            srst_busy <= 1'b0;
            if (wr_ctl) begin
                ctl       <= ctl_from_word(wr_data[31:0]);
                srst_busy <= wr_data[B_SRST];
            end
            if (wr_en && idx == IDX_LOAD) load_val <= wr_data;
            if (wr_en && idx == IDX_CMP)  cmp_val  <= wr_data;
        end
    end
endmodule

// File: rtl/ivt_tick_gate.sv
module ivt_tick_gate
    import ivt_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  ivt_ctl_t        ctl,
    input  logic [NSRC-1:0] tick_src,
    input  logic            in_stop,
    input  logic            in_wait,
    input  logic            in_debug,
    output logic            step
);
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = tick_src[g] && (32'(ctl.tick_sel) == g + 1);
    end

    logic mode_ok;
    assign mode_ok = !(in_stop  && !ctl.stop_run) &&
                     !(in_wait  && !ctl.wait_run) &&
                     !(in_debug && !ctl.dbg_run);

    assign step = ctl.run_en && mode_ok && (|hit);
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          srst_busy,
    input  logic          step,
    input  logic          thru_load,
    input  logic [DW-1:0] thru_val,
    input  logic          start_load,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] cmp_val,
    input  logic          reload_sel,
    input  logic          clr_req,
    output logic [DW-1:0] cnt,
    output logic          flag
);
    localparam logic [DW-1:0] CNT_RST = '1;

    logic at_zero;
    assign at_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || srst_busy) begin
            cnt  <= CNT_RST;
            flag <= 1'b0;
        end else begin
            if (thru_load)
                cnt <= thru_val;
            else if (start_load)
                cnt <= load_val;
            else if (step)
                cnt <= at_zero ? (reload_sel ? load_val : CNT_RST) : cnt - 1'b1;

            if (step && cnt == cmp_val)
                flag <= 1'b1;
            else if (clr_req)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 5,
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic [NSRC-1:0] tick_src,
    input  logic            in_stop,
    input  logic            in_wait,
    input  logic            in_debug,
    output logic            irq
);
    ivt_ctl_t      ctl;
    logic [DW-1:0] load_val, cmp_val, cnt;
    logic          srst_busy, start_load, thru_load, clr_req, step, flag;

    ivt_regfile #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctl(ctl), .load_val(load_val), .cmp_val(cmp_val), .srst_busy(srst_busy),
        .start_load(start_load), .thru_load(thru_load), .clr_req(clr_req)
    );

    ivt_tick_gate #(.NSRC(NSRC)) u_gate (
        .ctl(ctl), .tick_src(tick_src), .in_stop(in_stop), .in_wait(in_wait),
        .in_debug(in_debug), .step(step)
    );

    ivt_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst(rst), .srst_busy(srst_busy), .step(step),
        .thru_load(thru_load), .thru_val(wr_data), .start_load(start_load),
        .load_val(load_val), .cmp_val(cmp_val), .reload_sel(ctl.reload_sel),
        .clr_req(clr_req), .cnt(cnt), .flag(flag)
    );

    assign irq = flag && ctl.irq_en;

    logic [2:0] rd_idx;
    assign rd_idx = 3'(rd_addr[AW-1:2]);

    logic unused_rd_lsb;
    assign unused_rd_lsb = ^rd_addr[1:0];

    always_comb begin
        case (rd_idx)
            IDX_CTL:  rd_data = DW'(ctl_to_word(ctl, srst_busy));
            IDX_STS:  rd_data = {{(DW-1){1'b0}}, flag};
            IDX_LOAD: rd_data = load_val;
            IDX_CMP:  rd_data = cmp_val;
            IDX_CNT:  rd_data = cnt;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          step,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] cmp_val,
    input logic          flag,
    input logic          srst_busy,
    input logic          clr_req,
    input logic          thru_load,
    input logic          start_load,
    input logic          in_stop,
    input logic          stop_run
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_dec_r2: assert property (@(posedge clk) disable iff (rst)
        (step && cnt != '0 && !srst_busy && !thru_load && !start_load)
        |=> (cnt == $past(cnt) - 1'b1));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!step && !srst_busy && !thru_load && !start_load) |=> $stable(cnt));

    p_flag_src_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(flag) |-> $past(step && cnt == cmp_val));

    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req && !srst_busy) |=> flag);

    p_srst_r8: assert property (@(posedge clk) disable iff (rst)
        srst_busy |=> (!flag && cnt == '1));

    p_mode_r9: assert property (@(posedge clk) disable iff (rst)
        (in_stop && !stop_run) |-> !step);
endmodule

bind ivt_timer ivt_timer_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .step(step), .cnt(cnt), .cmp_val(cmp_val), .flag(flag),
    .srst_busy(srst_busy), .clr_req(clr_req), .thru_load(thru_load),
    .start_load(start_load), .in_stop(in_stop), .stop_run(ctl.stop_run)
);

// File: tb/ivt_timer_test.sv
module ivt_timer_test;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int NSRC = 3;

    localparam logic [AW-1:0] A_CTL = 5'h00, A_STS = 5'h04, A_LOAD = 5'h08,
                              A_CMP = 5'h0C, A_CNT = 5'h10, A_BAD = 5'h14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [NSRC-1:0] tick_src = '0;
    logic in_stop = 1'b0, in_wait = 1'b0, in_debug = 1'b0;
    logic irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ivt_timer #(.DW(DW), .AW(AW), .NSRC(NSRC)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick_src(tick_src),
        .in_stop(in_stop), .in_wait(in_wait), .in_debug(in_debug), .irq(irq)
    );

    task automatic expect_reg(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        rd_addr = a;
        #1;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s: addr %h got %h expected %h", tag, a, rd_data, exp);
        end
    endtask

    task automatic expect_irq(input logic exp, input string tag);
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input logic [NSRC-1:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            tick_src = m;
            @(negedge clk);
            tick_src = '0;
        end
    endtask

    task automatic t_reset;
        expect_reg(A_CTL, 32'h0, "R1 ctl");
        expect_reg(A_STS, 32'h0, "R1 sts");
        expect_reg(A_LOAD, 32'h0, "R1 load");
        expect_reg(A_CNT, 32'hFFFF_FFFF, "R1 cnt");
        expect_irq(1'b0, "R1 irq");
    endtask

    task automatic t_regmap;
        wr(A_LOAD, 32'd5);
        wr(A_CMP, 32'd7);
        expect_reg(A_LOAD, 32'd5, "R11 load");
        expect_reg(A_CMP, 32'd7, "R11 cmp");
        expect_reg(A_BAD, 32'h0, "R11 unmapped");
        expect_reg(A_CNT, 32'hFFFF_FFFF, "R11 cnt untouched");
    endtask

    task automatic t_count;
        wr(A_CTL, 32'h0100_0001);
        tick(3'b001, 3);
        expect_reg(A_CNT, 32'hFFFF_FFFC, "R2 decrement");
        tick(3'b010, 2);
        expect_reg(A_CNT, 32'hFFFF_FFFC, "R2 unselected source");
        wr(A_CTL, 32'h0000_0001);
        tick(3'b111, 2);
        expect_reg(A_CNT, 32'hFFFF_FFFC, "R2 source 0 frozen");
        wr(A_CTL, 32'h0300_0001);
        tick(3'b100, 1);
        expect_reg(A_CNT, 32'hFFFF_FFFB, "R2 source 3");
    endtask

    task automatic t_reload;
        wr(A_CTL, 32'h0);
        wr(A_LOAD, 32'd3);
        wr(A_CTL, 32'h0100_000B);
        expect_reg(A_CNT, 32'd3, "R4 load on start");
        tick(3'b001, 3);
        expect_reg(A_CNT, 32'd0, "R3 reach zero");
        tick(3'b001, 1);
        expect_reg(A_CNT, 32'd3, "R3 reload");
        wr(A_CTL, 32'h0100_0001);
        tick(3'b001, 3);
        tick(3'b001, 1);
        expect_reg(A_CNT, 32'hFFFF_FFFF, "R3 wrap");
    endtask

    task automatic t_compare;
        wr(A_CMP, 32'd2);
        wr(A_CTL, 32'h0102_0004);
        wr(A_LOAD, 32'd4);
        expect_reg(A_CNT, 32'd4, "R5 write-through while off");
        wr(A_CTL, 32'h0102_0005);
        tick(3'b001, 2);
        expect_reg(A_STS, 32'd0, "R6 no match yet");
        tick(3'b001, 1);
        expect_reg(A_STS, 32'd1, "R6 flag on match");
        expect_irq(1'b1, "R6 irq");
        wr(A_CTL, 32'h0102_0001);
        expect_irq(1'b0, "R6 irq gated");
    endtask

    task automatic t_w1c;
        wr(A_STS, 32'd0);
        expect_reg(A_STS, 32'd1, "R7 write zero");
        wr(A_STS, 32'd1);
        expect_reg(A_STS, 32'd0, "R7 write one");
        wr(A_LOAD, 32'd2);
        wr_en = 1'b1; wr_addr = A_STS; wr_data = 32'd1; tick_src = 3'b001;
        @(negedge clk);
        wr_en = 1'b0; tick_src = '0;
        expect_reg(A_STS, 32'd1, "R7 set wins");
        expect_reg(A_CNT, 32'd1, "R7 count");
    endtask

    task automatic t_disable;
        wr(A_CTL, 32'h0102_0000);
        tick(3'b001, 3);
        expect_reg(A_CNT, 32'd1, "R10 count frozen");
        expect_reg(A_STS, 32'd1, "R10 flag kept");
    endtask

    task automatic t_modes;
        wr(A_STS, 32'd1);
        wr(A_CTL, 32'h0100_0001);
        in_stop = 1'b1;
        tick(3'b001, 1);
        expect_reg(A_CNT, 32'd1, "R9 stop blocks");
        wr(A_CTL, 32'h0120_0001);
        tick(3'b001, 1);
        expect_reg(A_CNT, 32'd0, "R9 stop allowed");
        in_stop = 1'b0; in_debug = 1'b1;
        tick(3'b001, 1);
        expect_reg(A_CNT, 32'd0, "R9 debug blocks");
        wr(A_CTL, 32'h0104_0001);
        tick(3'b001, 1);
        expect_reg(A_CNT, 32'hFFFF_FFFF, "R9 debug allowed");
        in_debug = 1'b0; in_wait = 1'b1;
        tick(3'b001, 1);
        expect_reg(A_CNT, 32'hFFFF_FFFF, "R9 wait blocks");
        in_wait = 1'b0;
    endtask

    task automatic t_soft_reset;
        wr(A_CTL, 32'h0102_0001);
        wr(A_LOAD, 32'd2);
        tick(3'b001, 1);
        expect_reg(A_STS, 32'd1, "R8 flag before");
        wr(A_CTL, 32'h0103_0005);
        expect_reg(A_CTL, 32'h0103_0005, "R8 busy bit visible");
        @(negedge clk);
        expect_reg(A_CTL, 32'h0102_0005, "R8 busy bit cleared");
        expect_reg(A_CNT, 32'hFFFF_FFFF, "R8 count reset");
        expect_reg(A_STS, 32'd0, "R8 flag reset");
        expect_irq(1'b0, "R8 irq");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_count();
        t_reload();
        t_compare();
        t_w1c();
        t_disable();
        t_modes();
        t_soft_reset();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule